// File: doc/BRIEF.md
# Configuration Frame Scrubber

This controller repairs upsets in the configuration memory of a programmable device while that device keeps running. It visits the frames in ascending address order and handles one frame at a time. For each frame it first fetches the whole golden frame from an external non-volatile store. The golden words go into a local buffer. It then reads the live frame back through the configuration port and compares it, bit for bit, against the buffer. A live frame that matches is left alone. A live frame with any difference is overwritten in place with the buffered golden words, and no second fetch from the golden store is needed.

After every rewrite, the frame is read back once more. A frame that still differs points to a hard fault rather than a transient. The controller sets a sticky flag, records the frame address, and moves on to the next frame. Two saturating counters report the radiation environment: one counts mismatching frames and one accumulates the number of differing bits. A single-cycle pulse marks the end of each full pass. In continuous mode the walk wraps back to frame 0. A stop request takes effect only at the next frame boundary.

Top module: `frame_scrubber`

## Requirements
- R1: After start, frames are visited from 0 upward. For each frame, word 0 to FRAME_WORDS-1 of the golden copy are all requested before the first live readback request. Live words are then requested in word order. Only one request is outstanding at a time.
- R2: A frame is rewritten only when its first readback differs from the golden copy in at least one bit. The rewrite drives `cfg_wr_en` for FRAME_WORDS consecutive cycles, carrying the golden words in word order for that frame. A matching frame gets no write.
- R3: `upset_cnt` rises by one for each frame whose first readback mismatches. It holds at all-ones once saturated.
- R4: `bit_cnt` adds the popcount of (live XOR golden) for every word of a first readback. Bits seen during the verify readback are not added. It saturates at all-ones.
- R5: A `clr_cnt` pulse zeroes `upset_cnt`, `bit_cnt` and `stuck_err` on the next clock. The clear takes priority over a simultaneous increment.
- R6: After a rewrite, the frame is read once more. If that readback still differs, `stuck_err` is set and stays set until cleared, and `stuck_frame` takes the frame address. Scrubbing then continues with the next frame.
- R7: `pass_done` is high for exactly one cycle after the last frame is finished. Without `cont`, `busy` falls in that same cycle. With `cont` set, `busy` stays high and the next golden request is frame 0, word 0.
- R8: A one-cycle `stop` while busy is held pending. The current frame completes, and `busy` then falls with no request made for the following frame.
- R9: Out of reset, `busy`, `pass_done`, all strobes, both counters and `stuck_err` are 0. No strobe is driven while `busy` is low, and at most one of `gold_req`, `cfg_rd_req` and `cfg_wr_en` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass at frame 0 (accepted only when idle) |
| stop | input | 1 | Request a halt at the next frame boundary |
| cont | input | 1 | Wrap to frame 0 after the last frame |
| clr_cnt | input | 1 | Clear both counters and the sticky error |
| gold_req | output | 1 | Golden word request strobe |
| gold_valid | input | 1 | Golden word return strobe |
| gold_data | input | WORD_W | Golden word |
| cfg_rd_req | output | 1 | Live word readback request strobe |
| cfg_rd_valid | input | 1 | Live word return strobe |
| cfg_rd_data | input | WORD_W | Live word |
| cfg_wr_en | output | 1 | Live word write strobe |
| cfg_wr_data | output | WORD_W | Word written to the live frame |
| frame_addr | output | clog2(NUM_FRAMES) | Frame address for all three strobes |
| word_addr | output | clog2(FRAME_WORDS) | Word index within the frame |
| busy | output | 1 | High from start until the walk halts |
| pass_done | output | 1 | One-cycle end-of-pass pulse |
| upset_cnt | output | CNT_W | Mismatching-frame count, saturating |
| bit_cnt | output | CNT_W | Differing-bit count, saturating |
| stuck_err | output | 1 | Sticky flag: a rewrite did not take |
| stuck_frame | output | clog2(NUM_FRAMES) | Frame that last failed its verify |

## Verification
The assertions assume that the two return strobes are well behaved. Each `gold_valid` or `cfg_rd_valid` must answer exactly one preceding request on the matching port. No return may arrive unasked, and a return must come before the next request on that port. The memory models in the bench answer every request on the cycle after it and never otherwise, so the return timing always stays within that contract. Rewrites are made to fail by a model of a stuck bit in one frame, and the full-inversion passes drive both counters into saturation.

// File: rtl/frame_scrubber.sv
module frame_scrubber #(
  parameter int WORD_W      = 32,
  parameter int FRAME_WORDS = 32,
  parameter int NUM_FRAMES  = 1024,
  parameter int CNT_W       = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           stop,
  input  logic                           cont,
  input  logic                           clr_cnt,
  output logic                           gold_req,
  input  logic                           gold_valid,
  input  logic [WORD_W-1:0]              gold_data,
  output logic                           cfg_rd_req,
  input  logic                           cfg_rd_valid,
  input  logic [WORD_W-1:0]              cfg_rd_data,
  output logic                           cfg_wr_en,
  output logic [WORD_W-1:0]              cfg_wr_data,
  output logic [$clog2(NUM_FRAMES)-1:0]  frame_addr,
  output logic [$clog2(FRAME_WORDS)-1:0] word_addr,
  output logic                           busy,
  output logic                           pass_done,
  output logic [CNT_W-1:0]               upset_cnt,
  output logic [CNT_W-1:0]               bit_cnt,
  output logic                           stuck_err,
  output logic [$clog2(NUM_FRAMES)-1:0]  stuck_frame
);
  localparam int FA_W = $clog2(NUM_FRAMES);
  localparam int WI_W = $clog2(FRAME_WORDS);
  localparam int PC_W = $clog2(WORD_W + 1);
  localparam logic [WI_W-1:0] LAST_W = WI_W'(FRAME_WORDS - 1);
  localparam logic [FA_W-1:0] LAST_F = FA_W'(NUM_FRAMES - 1);

  typedef enum logic [2:0] {S_IDLE, S_GREQ, S_GWAIT, S_LREQ, S_LWAIT, S_WR, S_NEXT} st_t;
  st_t st;

  logic [WORD_W-1:0] gbuf [FRAME_WORDS];
  logic              mism, vfy, stop_pend;
  logic [WORD_W-1:0] diff;
  logic              mism_nxt;
  logic [CNT_W:0]    bsum;

  function automatic logic [PC_W-1:0] popc(input logic [WORD_W-1:0] v);
    popc = '0;
    for (int i = 0; i < WORD_W; i++) popc = popc + PC_W'(v[i]);
  endfunction

  assign gold_req    = (st == S_GREQ);
  assign cfg_rd_req  = (st == S_LREQ);
  assign cfg_wr_en   = (st == S_WR);
  assign cfg_wr_data = gbuf[word_addr];
  assign busy        = (st != S_IDLE);
  assign diff        = cfg_rd_data ^ gbuf[word_addr];
  assign mism_nxt    = mism | (|diff);
  assign bsum        = {1'b0, bit_cnt} + (CNT_W+1)'(popc(diff));

  always_ff @(posedge clk)
    if (st == S_GWAIT && gold_valid) gbuf[word_addr] <= gold_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; frame_addr <= '0; word_addr <= '0;
      mism <= 1'b0; vfy <= 1'b0; stop_pend <= 1'b0; pass_done <= 1'b0;
      upset_cnt <= '0; bit_cnt <= '0; stuck_err <= 1'b0; stuck_frame <= '0;
    end else begin
      pass_done <= 1'b0;
      if (stop && busy) stop_pend <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          frame_addr <= '0; word_addr <= '0; stop_pend <= 1'b0; st <= S_GREQ;
        end
        S_GREQ: st <= S_GWAIT;
        S_GWAIT: if (gold_valid) begin
          if (word_addr == LAST_W) begin
            word_addr <= '0; mism <= 1'b0; vfy <= 1'b0; st <= S_LREQ;
          end else begin
            word_addr <= word_addr + WI_W'(1); st <= S_GREQ;
          end
        end
        S_LREQ: st <= S_LWAIT;
        S_LWAIT: if (cfg_rd_valid) begin
          mism <= mism_nxt;
          if (!vfy) bit_cnt <= bsum[CNT_W] ? '1 : bsum[CNT_W-1:0];
          if (word_addr == LAST_W) begin
            word_addr <= '0;
            if (vfy) begin
              if (mism_nxt) begin stuck_err <= 1'b1; stuck_frame <= frame_addr; end
              st <= S_NEXT;
            end else if (mism_nxt) begin
              if (!(&upset_cnt)) upset_cnt <= upset_cnt + CNT_W'(1);
              st <= S_WR;
            end else st <= S_NEXT;
          end else begin
            word_addr <= word_addr + WI_W'(1); st <= S_LREQ;
          end
        end
        S_WR: if (word_addr == LAST_W) begin
          word_addr <= '0; vfy <= 1'b1; mism <= 1'b0; st <= S_LREQ;
        end else word_addr <= word_addr + WI_W'(1);
        S_NEXT: if (frame_addr == LAST_F) begin
          pass_done <= 1'b1;
          frame_addr <= '0;
          st <= (cont && !stop_pend) ? S_GREQ : S_IDLE;
        end else if (stop_pend) st <= S_IDLE;
        else begin
          frame_addr <= frame_addr + FA_W'(1); st <= S_GREQ;
        end
        default: st <= S_IDLE;
      endcase
      if (clr_cnt) begin
        upset_cnt <= '0; bit_cnt <= '0; stuck_err <= 1'b0;
      end
    end
  end

  p_pass_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> !pass_done);
  p_upset_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&upset_cnt && !clr_cnt) |=> &upset_cnt);
  p_bits_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cnt |=> bit_cnt >= $past(bit_cnt));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt |=> (upset_cnt == '0 && bit_cnt == '0 && !stuck_err));
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stuck_err && !clr_cnt) |=> stuck_err);
  p_wr_after_upset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_wr_en) && !$past(clr_cnt)) |-> (upset_cnt != $past(upset_cnt) || &upset_cnt));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!gold_req && !cfg_rd_req && !cfg_wr_en));
endmodule

// File: tb/sim_frame_scrubber.sv
module sim_frame_scrubber;
  localparam int WW = 32, FW = 4, NF = 8, CW = 8;
  localparam int STUCK_F = 3;
  localparam longint CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic start = 0, stop = 0, cont = 0, clr_cnt = 0;
  logic gold_req, gold_valid = 0, cfg_rd_req, cfg_rd_valid = 0, cfg_wr_en;
  logic [WW-1:0] gold_data = '0, cfg_rd_data = '0, cfg_wr_data;
  logic [2:0] frame_addr, stuck_frame;
  logic [1:0] word_addr;
  logic busy, pass_done, stuck_err;
  logic [CW-1:0] upset_cnt, bit_cnt;

  always #10 clk = ~clk;

  frame_scrubber #(.WORD_W(WW), .FRAME_WORDS(FW), .NUM_FRAMES(NF), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .cont(cont), .clr_cnt(clr_cnt),
    .gold_req(gold_req), .gold_valid(gold_valid), .gold_data(gold_data),
    .cfg_rd_req(cfg_rd_req), .cfg_rd_valid(cfg_rd_valid), .cfg_rd_data(cfg_rd_data),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .frame_addr(frame_addr),
    .word_addr(word_addr), .busy(busy), .pass_done(pass_done), .upset_cnt(upset_cnt),
    .bit_cnt(bit_cnt), .stuck_err(stuck_err), .stuck_frame(stuck_frame));

  logic [WW-1:0] gold [NF][FW];
  logic [WW-1:0] live [NF][FW];
  bit stuck_on = 1;
  bit mm_exp [NF];
  int nchk = 0, nfail = 0, cyc = 0;
  int eg_f = 0, eg_w = 0, wcount = 0, rd_f1 = 0, g_f2 = 0;
  bit prev_busy = 0;
  longint exp_up = 0, exp_bits = 0;
  bit exp_err = 0;
  int exp_ef = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory models: one-cycle response, stuck bit in one frame
  always @(posedge clk) begin
    gold_valid   <= gold_req;
    gold_data    <= gold[frame_addr][word_addr];
    cfg_rd_valid <= cfg_rd_req;
    cfg_rd_data  <= live[frame_addr][word_addr];
    if (cfg_wr_en)
      live[frame_addr][word_addr] <= cfg_wr_data ^
        ((stuck_on && frame_addr == STUCK_F && word_addr == 0) ? 32'h1 : 32'h0);
  end

  // per-clock monitor
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      chk($countones({gold_req, cfg_rd_req, cfg_wr_en}) <= 1, "R9 one strobe", {gold_req, cfg_rd_req, cfg_wr_en}, 0);
      if (!busy) chk(!(gold_req | cfg_rd_req | cfg_wr_en), "R9 quiet idle", {gold_req, cfg_rd_req, cfg_wr_en}, 0);
      if (busy && !prev_busy) begin eg_f = 0; eg_w = 0; end
      if (gold_req) begin
        chk(frame_addr == eg_f && word_addr == eg_w, "R1 golden order", {frame_addr, word_addr}, eg_f * 4 + eg_w);
        if (frame_addr == 2) g_f2++;
        eg_w++;
        if (eg_w == FW) begin eg_w = 0; eg_f = (eg_f + 1) % NF; end
      end
      if (cfg_rd_req) begin
        chk(eg_w == 0 && frame_addr == (eg_f + NF - 1) % NF, "R1 readback after fetch", frame_addr, (eg_f + NF - 1) % NF);
        if (frame_addr == 1) rd_f1++;
      end
      if (cfg_wr_en) begin
        wcount++;
        chk(cfg_wr_data == gold[frame_addr][word_addr], "R2 write data", cfg_wr_data, gold[frame_addr][word_addr]);
        chk(mm_exp[frame_addr], "R2 write only on mismatch", frame_addr, 0);
      end
      prev_busy = busy;
    end
  end

  initial begin
    #3000000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  task automatic tick;
    @(negedge clk); #1;
  endtask

  function automatic longint sat(input longint v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic predict;
    for (int f = 0; f < NF; f++) begin
      int b = 0;
      for (int w = 0; w < FW; w++) b += $countones(gold[f][w] ^ live[f][w]);
      mm_exp[f] = (b != 0);
      if (b != 0) begin
        exp_up = sat(exp_up + 1);
        exp_bits = sat(exp_bits + b);
        if (stuck_on && f == STUCK_F) begin exp_err = 1; exp_ef = f; end
      end
    end
  endtask

  task automatic run_pass;
    int nmm = 0, w0, lim = 0;
    predict();
    for (int f = 0; f < NF; f++) if (mm_exp[f]) nmm++;
    w0 = wcount;
    start = 1; tick(); start = 0;
    while (!pass_done && lim < 5000) begin tick(); lim++; end
    chk(pass_done == 1, "R7 pass pulse", pass_done, 1);
    chk(busy == 0, "R7 busy falls", busy, 0);
    tick();
    chk(pass_done == 0, "R7 one cycle", pass_done, 0);
    chk(upset_cnt == exp_up, "R3 upset count", upset_cnt, exp_up);
    chk(bit_cnt == exp_bits, "R4 bit count", bit_cnt, exp_bits);
    chk(stuck_err == exp_err, "R6 sticky flag", stuck_err, exp_err);
    if (exp_err) chk(stuck_frame == exp_ef, "R6 stuck frame", stuck_frame, exp_ef);
    chk(wcount - w0 == nmm * FW, "R2 write count", wcount - w0, nmm * FW);
    for (int f = 0; f < NF; f++)
      if (!(stuck_on && f == STUCK_F))
        for (int w = 0; w < FW; w++)
          chk(live[f][w] == gold[f][w], "R2 repaired", live[f][w], gold[f][w]);
  endtask

  initial begin
    for (int f = 0; f < NF; f++)
      for (int w = 0; w < FW; w++) begin
        gold[f][w] = (32'h9E3779B9 * (f * FW + w + 1)) ^ (f << 16);
        live[f][w] = gold[f][w];
      end
    live[2][1] ^= 32'h10;
    live[3][0] ^= 32'h80;
    live[5][0] ^= 32'h3;
    live[5][3] ^= 32'h8000_0000;
    live[7][2] ^= 32'h200;
    repeat (4) tick();
    rst_n = 1;
    tick();
    chk(!busy && !pass_done && upset_cnt == 0 && bit_cnt == 0 && !stuck_err, "R9 reset state",
        {busy, pass_done, upset_cnt, bit_cnt, stuck_err}, 0);
    chk(!(gold_req | cfg_rd_req | cfg_wr_en), "R9 reset strobes", {gold_req, cfg_rd_req, cfg_wr_en}, 0);

    run_pass();
    run_pass();

    clr_cnt = 1; tick(); clr_cnt = 0;
    chk(upset_cnt == 0 && bit_cnt == 0 && !stuck_err, "R5 clear", {upset_cnt, bit_cnt, stuck_err}, 0);
    exp_up = 0; exp_bits = 0; exp_err = 0;

    begin
      int lim = 0, base_rd, base_g2;
      predict();
      cont = 1;
      start = 1; tick(); start = 0;
      while (!pass_done && lim < 5000) begin tick(); lim++; end
      chk(pass_done && busy, "R7 continuous keeps busy", {pass_done, busy}, 3);
      lim = 0;
      while (!gold_req && lim < 100) begin tick(); lim++; end
      chk(frame_addr == 0 && word_addr == 0, "R7 wrap to frame 0", {frame_addr, word_addr}, 0);
      lim = 0;
      while (!(gold_req && frame_addr == 1) && lim < 1000) begin tick(); lim++; end
      base_rd = rd_f1; base_g2 = g_f2;
      stop = 1; tick(); stop = 0;
      lim = 0;
      while (busy && lim < 1000) begin tick(); lim++; end
      repeat (3) tick();
      chk(!busy, "R8 halted", busy, 0);
      chk(rd_f1 - base_rd == FW, "R8 frame completed", rd_f1 - base_rd, FW);
      chk(g_f2 == base_g2, "R8 no next frame", g_f2 - base_g2, 0);
      cont = 0;
    end

    clr_cnt = 1; tick(); clr_cnt = 0;
    exp_up = 0; exp_bits = 0; exp_err = 0;
    stuck_on = 0;
    for (int p = 0; p < 33; p++) begin
      for (int f = 0; f < NF; f++)
        for (int w = 0; w < FW; w++) live[f][w] = ~gold[f][w];
      run_pass();
    end
    chk(upset_cnt == CMAX, "R3 saturated", upset_cnt, CMAX);
    chk(bit_cnt == CMAX, "R4 saturated", bit_cnt, CMAX);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule